// File: doc/BRIEF.md
# Codec Host Sample Port

This block sits between a host processor and the digital sample path of a line codec. The host moves 16-bit two's-complement words over a shared data bus using three active-low strobes. A write strobe, qualified by chip select, loads a transmit word. An output enable, also qualified by chip select, puts the current receive word on the bus. The strobes are sampled through a short synchronizer, and each data direction acts on a strobe edge or a strobe level.

On the receive side, every converter word has a programmable 16-bit two's-complement offset added to it. The sum saturates instead of wrapping, and the result goes into the receive buffer. Two routing controls change where the words go. Sample loopback sends the receive buffer into the transmit stream. Host readback returns the host's transmit word through the receive buffer and skips the converter path. Both buffers update only on a sample tick, and the tick runs at one of two rates picked by a rate select input. The converters themselves appear only as sample-stream ports.

Top module: `codec_host_port`

## Requirements
- R1: After reset, `dout_en` is 0, `dac_valid` is 0 and `dac_sample` is 0x0000. A bus read made before the first sample tick returns 0x0000.
- R2: `sample_tick` occurs once every 16 clock cycles when `rate_fast` is 0 and once every 8 cycles when it is 1. `dac_valid` is a single-cycle pulse in the cycle after each tick, and two such pulses are never adjacent.
- R3: A rising edge of `we_n` seen while `cs_n` is low captures `din` as the host word. That word appears on `dac_sample` at the next `dac_valid` pulse when loopback is off.
- R4: While `cs_n` is high, a `we_n` rising edge leaves the host word unchanged, and `dout_en` stays 0 even when `oe_n` is low.
- R5: `dout_en` rises two clock edges after the later of `cs_n` and `oe_n` goes low. It falls two edges after the first of them goes high. When `dout_en` is 0, `dout` is 0x0000.
- R6: With both routing controls off, each tick loads the receive buffer with `adc_sample + offset`. Both operands are 16-bit two's complement with bit 0 as the LSB.
- R7: The receive sum saturates at 0x7FFF for positive overflow and at 0x8000 for negative overflow.
- R8: With `loop_en` set to 1, the word placed on `dac_sample` at a tick is the receive-buffer word held just before that tick. The host word is not used.
- R9: With `readback_en` set to 1, each tick loads the receive buffer with the host word. `adc_sample` and `offset` are ignored.
- R10: Between `dac_valid` pulses, `dac_sample` holds its value. While the bus is driven, `dout` changes only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_fast | input | 1 | 1 selects the fast sample-tick period, 0 the slow one |
| cs_n | input | 1 | Active-low chip select that qualifies both strobes |
| oe_n | input | 1 | Active-low output enable for bus reads |
| we_n | input | 1 | Active-low write strobe; its rising edge captures the word |
| din | input | 16 | Data arriving from the bus |
| dout | output | 16 | Receive word sent to the bus (0 when not driven) |
| dout_en | output | 1 | Bus drive enable; 0 means high impedance |
| offset | input | 16 | Two's-complement DC correction added to the receive word |
| loop_en | input | 1 | Sample loopback: receive buffer feeds the transmit stream |
| readback_en | input | 1 | Host readback: host word feeds the receive buffer |
| adc_sample | input | 16 | Receive converter word, taken on each tick |
| dac_sample | output | 16 | Transmit word toward the converter |
| dac_valid | output | 1 | Pulse marking a new `dac_sample` |
| sample_tick | output | 1 | Sample-rate tick |

## Verification
Several internal faults show up at the ports. A wrong tick counter shows as a wrong gap between `dac_valid` pulses within one sample period. A bad offset adder or saturation limit shows in the first bus read after the next tick. A swapped route select shows on `dac_sample` or the bus within one or two ticks, because loopback delays the word by exactly one tick. A strobe qualification fault shows either as a word written while deselected reaching `dac_sample` at the next tick, or as `dout_en` rising too early or while deselected.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

    localparam int DATA_W = 16;

    typedef logic [DATA_W-1:0] word_t;

    // Host strobes as seen after the synchronizer (all active low)
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    // Routing controls for the sample path
    typedef struct packed {
        logic loop_en;
        logic readback_en;
    } route_t;

    // Source of the receive buffer word
    typedef enum logic {
        RX_FROM_CONV = 1'b0,
        RX_FROM_HOST = 1'b1
    } rx_src_e;

    // Source of the transmit stream word
    typedef enum logic {
        TX_FROM_HOST = 1'b0,
        TX_FROM_RXBUF = 1'b1
    } tx_src_e;

    localparam word_t WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam word_t WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    // Two's-complement add that clamps instead of wrapping
    function automatic word_t sat_add(word_t a, word_t b);
        logic [DATA_W:0] s;
        s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
        if (s[DATA_W] != s[DATA_W-1])
            return s[DATA_W] ? WORD_MIN : WORD_MAX;
        return s[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/codec_rate_gen.sv
module codec_rate_gen
    import codec_port_pkg::*;
#(
    parameter int SLOW_DIV = 16,
    parameter int FAST_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_fast,
    output logic tick
);
    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim  = rate_fast ? FAST_LIM : SLOW_LIM;
    // >= lets a switch to the short period take effect without a long wait
    assign tick = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/codec_strobe_if.sv
module codec_strobe_if
    import codec_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  oe_n,
    input  logic  we_n,
    input  word_t din,
    output word_t host_word,
    output logic  bus_drive
);
    localparam int LAST = SYNC_STAGES - 1;

    strobe_t stb_q [SYNC_STAGES];
    word_t   dat_q [SYNC_STAGES];
    logic    we_prev_q;
    logic    write_fire;
    strobe_t stb_s;

    // Strobes and data travel through the same number of stages
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    stb_q[g] <= '1;
                    dat_q[g] <= '0;
                end else begin
                    stb_q[g] <= '{cs_n: cs_n, oe_n: oe_n, we_n: we_n};
                    dat_q[g] <= din;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    stb_q[g] <= '1;
                    dat_q[g] <= '0;
                end else begin
                    stb_q[g] <= stb_q[g-1];
                    dat_q[g] <= dat_q[g-1];
                end
            end
        end
    end

    assign stb_s      = stb_q[LAST];
    assign write_fire = stb_s.we_n && !we_prev_q && !stb_s.cs_n;
    assign bus_drive  = !stb_s.cs_n && !stb_s.oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_prev_q <= 1'b1;
            host_word <= '0;
        end else begin
            we_prev_q <= stb_s.we_n;
            if (write_fire)
                host_word <= dat_q[LAST];
        end
    end
endmodule

// File: rtl/codec_sample_path.sv
module codec_sample_path
    import codec_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  route_t route,
    input  word_t  offset,
    input  word_t  adc_sample,
    input  word_t  host_word,
    output word_t  rx_word,
    output word_t  dac_sample,
    output logic   dac_valid
);
    rx_src_e rx_src;
    tx_src_e tx_src;
    word_t   rx_next;
    word_t   tx_next;
    word_t   corrected;

    assign corrected = sat_add(adc_sample, offset);
    assign rx_src    = route.readback_en ? RX_FROM_HOST : RX_FROM_CONV;
    assign tx_src    = route.loop_en ? TX_FROM_RXBUF : TX_FROM_HOST;

    always_comb begin
        unique case (rx_src)
            RX_FROM_HOST: rx_next = host_word;
            default:      rx_next = corrected;
        endcase
        unique case (tx_src)
            TX_FROM_RXBUF: tx_next = rx_word;
            default:       tx_next = host_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word    <= '0;
            dac_sample <= '0;
            dac_valid  <= 1'b0;
        end else begin
            dac_valid <= tick;
            if (tick) begin
                rx_word    <= rx_next;
                dac_sample <= tx_next;
            end
        end
    end
endmodule

// File: rtl/codec_host_port.sv
module codec_host_port
    import codec_port_pkg::*;
#(
    parameter int SLOW_DIV    = 16,
    parameter int FAST_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rate_fast,
    input  logic        cs_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [15:0] din,
    output logic [15:0] dout,
    output logic        dout_en,
    input  logic [15:0] offset,
    input  logic        loop_en,
    input  logic        readback_en,
    input  logic [15:0] adc_sample,
    output logic [15:0] dac_sample,
    output logic        dac_valid,
    output logic        sample_tick
);
    word_t  host_word;
    word_t  rx_word;
    route_t route;

    assign route = '{loop_en: loop_en, readback_en: readback_en};

    codec_rate_gen #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_rate (
        .clk       (clk),
        .rst       (rst),
        .rate_fast (rate_fast),
        .tick      (sample_tick)
    );

    codec_strobe_if #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .din       (din),
        .host_word (host_word),
        .bus_drive (dout_en)
    );

    codec_sample_path u_path (
        .clk        (clk),
        .rst        (rst),
        .tick       (sample_tick),
        .route      (route),
        .offset     (offset),
        .adc_sample (adc_sample),
        .host_word  (host_word),
        .rx_word    (rx_word),
        .dac_sample (dac_sample),
        .dac_valid  (dac_valid)
    );

    assign dout = dout_en ? rx_word : '0;
endmodule

// File: rtl/codec_port_checker.sv
module codec_port_checker (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        oe_n,
    input logic [15:0] dout,
    input logic        dout_en,
    input logic [15:0] dac_sample,
    input logic        dac_valid,
    input logic        sample_tick
);
    // R5
    bus_qual_chk: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> $past(!cs_n && !oe_n, 2));

    // R5
    bus_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == 16'h0000));

    // R2
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        dac_valid |-> $past(sample_tick));

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        dac_valid |=> !dac_valid);

    // R10
    dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dac_valid |-> $stable(dac_sample));

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_en && $past(dout_en) && !$past(sample_tick)) |-> $stable(dout));
endmodule

bind codec_host_port codec_port_checker u_port_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .oe_n        (oe_n),
    .dout        (dout),
    .dout_en     (dout_en),
    .dac_sample  (dac_sample),
    .dac_valid   (dac_valid),
    .sample_tick (sample_tick)
);

// File: tb/test_codec_host_port.sv
module test_codec_host_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rate_fast = 1'b0;
    logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_en;
    logic [15:0] offset = '0;
    logic        loop_en = 1'b0, readback_en = 1'b0;
    logic [15:0] adc_sample = '0;
    logic [15:0] dac_sample;
    logic        dac_valid;
    logic        sample_tick;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    codec_host_port i_codec_host_port (
        .clk(clk), .rst(rst), .rate_fast(rate_fast),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .din(din),
        .dout(dout), .dout_en(dout_en), .offset(offset),
        .loop_en(loop_en), .readback_en(readback_en),
        .adc_sample(adc_sample), .dac_sample(dac_sample),
        .dac_valid(dac_valid), .sample_tick(sample_tick)
    );

    function automatic logic [15:0] ref_sat(logic [15:0] a, logic [15:0] b);
        int s;
        s = int'($signed(a)) + int'($signed(b));
        if (s > 32767) return 16'h7FFF;
        if (s < -32768) return 16'h8000;
        return s[15:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_tick();
        @(negedge clk);
        while (!dac_valid) @(negedge clk);
    endtask

    task automatic host_write(logic [15:0] w, bit selected);
        @(negedge clk);
        din  = w;
        cs_n = !selected;
        we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic host_read(output logic [15:0] w, output logic en);
        @(negedge clk);
        cs_n = 1'b0;
        oe_n = 1'b0;
        repeat (2) @(negedge clk);
        w  = dout;
        en = dout_en;
        cs_n = 1'b1;
        oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic        en;
        logic [15:0] a, o, h, held;
        int          gap;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 dout_en", dout_en, 0);
        check("R1 dac_valid", dac_valid, 0);
        check("R1 dac_sample", dac_sample, 0);
        host_read(rd, en);
        check("R1 first read", rd, 16'h0000);

        // R5 drive timing: two edges after both low, release two edges after rise
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        oe_n = 1'b0;
        @(negedge clk);
        check("R5 not yet driven", dout_en, 0);
        @(negedge clk);
        check("R5 driven", dout_en, 1);
        oe_n = 1'b1;
        @(negedge clk);
        check("R5 still driven", dout_en, 1);
        @(negedge clk);
        check("R5 released", dout_en, 0);
        check("R5 idle bus zero", dout, 0);
        cs_n = 1'b1;

        // R2 tick spacing at both rates
        next_tick();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!dac_valid);
        check("R2 slow period", gap, 16);
        rate_fast = 1'b1;
        next_tick();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!dac_valid);
        check("R2 fast period", gap, 8);
        rate_fast = 1'b0;
        next_tick();

        // R3 selected write reaches the transmit stream
        host_write(16'h1234, 1'b1);
        next_tick();
        check("R3 dac word", dac_sample, 16'h1234);

        // R4 deselected write and read are ignored
        host_write(16'hBEEF, 1'b0);
        @(negedge clk);
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 no drive while deselected", dout_en, 0);
        oe_n = 1'b1;
        next_tick();
        check("R4 host word kept", dac_sample, 16'h1234);

        // R6 and R7 directed offset cases
        adc_sample = 16'h0100; offset = 16'hFFF0;
        next_tick();
        host_read(rd, en);
        check("R6 offset sum", rd, 16'h00F0);
        check("R6 read enable", en, 1);
        adc_sample = 16'h7FF0; offset = 16'h0020;
        next_tick();
        host_read(rd, en);
        check("R7 positive clamp", rd, 16'h7FFF);
        adc_sample = 16'h8005; offset = 16'hFFF0;
        next_tick();
        host_read(rd, en);
        check("R7 negative clamp", rd, 16'h8000);
        adc_sample = 16'h7FFF; offset = 16'h0000;
        next_tick();
        host_read(rd, en);
        check("R7 edge no clamp", rd, 16'h7FFF);

        // R10 transmit word holds between ticks
        held = dac_sample;
        repeat (5) @(negedge clk);
        check("R10 dac hold", dac_sample, held);

        // R3 R6 R7 random traffic with fixed seed
        void'($urandom(32'd2024));
        for (int i = 0; i < 30; i++) begin
            a = 16'($urandom());
            o = (i % 3 == 0) ? 16'($urandom()) : 16'($urandom_range(0, 255) - 128);
            h = 16'($urandom());
            adc_sample = a; offset = o;
            host_write(h, 1'b1);
            next_tick();
            check("R3 random dac", dac_sample, h);
            host_read(rd, en);
            check("R6 R7 random rx", rd, ref_sat(a, o));
        end

        // R8 loopback: transmit carries the previous receive word
        adc_sample = 16'h0A5A; offset = 16'h0001; loop_en = 1'b1;
        host_write(16'h7777, 1'b1);
        next_tick();
        next_tick();
        check("R8 loopback word", dac_sample, 16'h0A5B);
        loop_en = 1'b0;

        // R9 readback: host word returns through receive buffer
        readback_en = 1'b1;
        adc_sample = 16'h1111; offset = 16'h2222;
        host_write(16'hC3C3, 1'b1);
        next_tick();
        host_read(rd, en);
        check("R9 readback word", rd, 16'hC3C3);
        readback_en = 1'b0;
        next_tick();
        host_read(rd, en);
        check("R9 back to converter", rd, 16'h3333);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule